// File: doc/BRIEF.md
# Packed Word Minimum Locator

This execution unit takes a 128-bit source operand, splits it into eight unsigned 16-bit lanes, and finds the smallest lane value and the lane that holds it. Lane i occupies source bits 16*i+15 down to 16*i. The value and its 3-bit lane number are packed into the low bits of a destination result that is as wide as the vector register. All other bits up to 127 are zero.

Two encoding modes decide what happens to result bits at 128 and above. In legacy mode those bits are copied from the old destination. In extended mode they are cleared. Extended mode also checks two encoding fields: a vector-length bit and a 4-bit spare-register field. An illegal value in either raises an undefined-opcode flag, and the destination is then left as it was.

The unit has one register stage. A result appears one clock after its input strobe. The operation touches no status flags and raises no floating-point exceptions, so the unit has no outputs for either.

Top module: `word_min_locate`

## Requirements
- R1: Result bits 15:0 equal the smallest unsigned 16-bit value among the eight source lanes, where lane i is source bits 16*i+15:16*i.
- R2: Result bits 18:16 hold the index (0 to 7) of the lane that supplied the minimum.
- R3: When several lanes share the minimum value, the lowest such lane index is reported.
- R4: For a legal operation, result bits 127:19 are zero.
- R5: In legacy mode (`in_mode`=0), result bits VLEN-1:128 equal the old destination bits. In this mode the length bit and spare-register field have no effect, and `out_undef` stays 0.
- R6: In extended mode (`in_mode`=1) with legal fields, result bits VLEN-1:128 are zero.
- R7: In extended mode, `out_undef` is 1 exactly when `in_len_bit` is 1 or `in_xreg` differs from 4'b1111.
- R8: When `out_undef` is 1, `out_result` equals the full old destination value.
- R9: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is sampled high. A synchronous active-high `rst` clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_src | input | 128 | Source with eight 16-bit lanes |
| in_dest_old | input | VLEN | Old destination register value |
| in_mode | input | 1 | 0 = legacy, 1 = extended |
| in_len_bit | input | 1 | Vector-length encoding bit (must be 0 in extended mode) |
| in_xreg | input | 4 | Spare register field (must be 4'b1111 in extended mode) |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | VLEN | Packed result |
| out_undef | output | 1 | Undefined-opcode flag |

## Verification
The bench uses inputs where every lane is equal and inputs where the minimum sits only in lane 7. A tree that breaks ties toward the higher lane would report index 7 for the first case. A tree that drops the last lane would miss the second. A minimum of zero and an all-0xFFFF source probe both ends of the unsigned range. A signed compare would pick 0x8000-class values over zero. Every one of the 31 illegal extended-mode field combinations is applied, and legacy mode is run with junk in those fields. This catches a checker that tests only one field or ignores the mode, and a design that leaks zeros or old bits across the 128-bit boundary.

// File: rtl/wml_pkg.sv
package wml_pkg;
    localparam int WORD_W = 16;
    localparam int LANES  = 8;
    localparam int SRC_W  = WORD_W * LANES;
    localparam int IDX_W  = $clog2(LANES);
    localparam int PACK_W = WORD_W + IDX_W;
    localparam logic [3:0] XREG_LEGAL = 4'b1111;

    typedef enum logic { ENC_LEGACY = 1'b0, ENC_EXTENDED = 1'b1 } enc_mode_e;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] val;
    } cand_t;

    // Right candidate (higher lanes) wins only when strictly smaller.
    function automatic cand_t pick_lower(input cand_t left, input cand_t right);
        return (right.val < left.val) ? right : left;
    endfunction
endpackage

// File: rtl/wml_min_tree.sv
module wml_min_tree
    import wml_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int LANE_W  = WORD_W
) (
    input  logic [N_LANES*LANE_W-1:0] src,
    output cand_t                     best
);
    localparam int NODES = 2 * N_LANES - 1;
    localparam int LEAF0 = N_LANES - 1;

    cand_t node [NODES];

    // Leaves laid out so every left subtree holds lower lane numbers.
    for (genvar i = 0; i < N_LANES; i++) begin : g_leaf
        assign node[LEAF0+i].val = src[i*LANE_W +: LANE_W];
        assign node[LEAF0+i].idx = IDX_W'(i);
    end

    for (genvar k = 0; k < LEAF0; k++) begin : g_stage
        assign node[k] = pick_lower(node[2*k+1], node[2*k+2]);
    end

    assign best = node[0];
endmodule

// File: rtl/wml_enc_check.sv
module wml_enc_check
    import wml_pkg::*;
(
    input  enc_mode_e  mode,
    input  logic       len_bit,
    input  logic [3:0] xreg,
    output logic       undef
);
    always_comb begin
        undef = 1'b0;
        if (mode == ENC_EXTENDED)
            undef = len_bit || (xreg != XREG_LEGAL);
    end
endmodule

// File: rtl/word_min_locate.sv
module word_min_locate
    import wml_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [127:0]    in_src,
    input  logic [VLEN-1:0] in_dest_old,
    input  logic            in_mode,
    input  logic            in_len_bit,
    input  logic [3:0]      in_xreg,
    output logic            out_valid,
    output logic [VLEN-1:0] out_result,
    output logic            out_undef
);
    localparam int UPPER_W = VLEN - SRC_W;

    initial begin
        if (VLEN < SRC_W) $error("VLEN must be at least 128");
    end

    cand_t     best;
    logic      undef_c;
    enc_mode_e mode_e;
    logic [VLEN-1:0] next_res;

    assign mode_e = enc_mode_e'(in_mode);

    wml_min_tree #(.N_LANES(LANES), .LANE_W(WORD_W)) tree_i (
        .src  (in_src),
        .best (best)
    );

    wml_enc_check enc_i (
        .mode    (mode_e),
        .len_bit (in_len_bit),
        .xreg    (in_xreg),
        .undef   (undef_c)
    );

    logic [SRC_W-1:0] low_part;
    assign low_part = {{(SRC_W-PACK_W){1'b0}}, best};

    if (VLEN > SRC_W) begin : g_upper
        logic [UPPER_W-1:0] upper;
        assign upper = (mode_e == ENC_LEGACY) ? in_dest_old[VLEN-1:SRC_W] : '0;
        assign next_res = undef_c ? in_dest_old : {upper, low_part};
    end else begin : g_exact
        assign next_res = undef_c ? in_dest_old : low_part;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_undef  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_undef  <= undef_c;
                out_result <= next_res;
            end
        end
    end

    p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_source_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));
    p_mid_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_undef) |-> (out_result[SRC_W-1:PACK_W] == '0));
    p_legacy_nofault_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(in_mode)) |-> !out_undef);
    p_fault_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_undef) |-> (out_result == $past(in_dest_old)));
    p_fault_rule_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_mode)) |->
            (out_undef == ($past(in_len_bit) || ($past(in_xreg) != XREG_LEGAL))));

    for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
        p_min_bound_r1: assert property (@(posedge clk) disable iff (rst)
            (out_valid && !out_undef) |->
                ($past(in_src[i*WORD_W +: WORD_W]) >= out_result[WORD_W-1:0]));
        p_low_index_r3: assert property (@(posedge clk) disable iff (rst)
            (out_valid && !out_undef && (32'(out_result[PACK_W-1:WORD_W]) > i)) |->
                ($past(in_src[i*WORD_W +: WORD_W]) > out_result[WORD_W-1:0]));
    end
endmodule

// File: tb/word_min_locate_tb.sv
module word_min_locate_tb_top;
    localparam int VLEN = 256;
    localparam time CLK_PERIOD = 10ns;

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic [127:0]    in_src;
    logic [VLEN-1:0] in_dest_old;
    logic            in_mode;
    logic            in_len_bit;
    logic [3:0]      in_xreg;
    logic            out_valid;
    logic [VLEN-1:0] out_result;
    logic            out_undef;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    word_min_locate #(.VLEN(VLEN)) dut_i (
        .clk, .rst, .in_valid, .in_src, .in_dest_old, .in_mode,
        .in_len_bit, .in_xreg, .out_valid, .out_result, .out_undef
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [VLEN-1:0] model(input logic [127:0] s,
            input logic [VLEN-1:0] d, input bit m, input bit l, input logic [3:0] x,
            output bit ud);
        logic [15:0] mn;
        logic [2:0]  ix;
        logic [VLEN-1:0] r;
        mn = s[15:0];
        ix = 3'd0;
        for (int i = 1; i < 8; i++) begin
            if (s[i*16 +: 16] < mn) begin
                mn = s[i*16 +: 16];
                ix = 3'(i);
            end
        end
        ud = m && (l || x != 4'b1111);
        if (ud) return d;
        r = '0;
        r[15:0]  = mn;
        r[18:16] = ix;
        if (!m) r[VLEN-1:128] = d[VLEN-1:128];
        return r;
    endfunction

    // Drive at negedge, check at the following negedge (one register stage).
    task automatic run_op(input logic [127:0] s, input logic [VLEN-1:0] d,
                          input bit m, input bit l, input logic [3:0] x, input string req);
        logic [VLEN-1:0] exp;
        bit ud;
        exp = model(s, d, m, l, x, ud);
        in_valid = 1'b1; in_src = s; in_dest_old = d;
        in_mode = m; in_len_bit = l; in_xreg = x;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1, "R9", "out_valid", VLEN'(out_valid), VLEN'(1));
        check(out_undef === ud, req, "out_undef", VLEN'(out_undef), VLEN'(ud));
        check(out_result === exp, req, "out_result", out_result, exp);
    endtask

    function automatic logic [VLEN-1:0] rnd_dest();
        logic [VLEN-1:0] v;
        for (int i = 0; i < VLEN/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b1; in_src = '0; in_dest_old = '0;
        in_mode = 1'b0; in_len_bit = 1'b0; in_xreg = 4'hF;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R9", "reset out_valid", VLEN'(out_valid), '0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R9", "idle out_valid", VLEN'(out_valid), '0);
    endtask

    task automatic t_ties();   // R3: all lanes equal -> lane 0
        run_op({8{16'h1234}}, rnd_dest(), 1'b0, 1'b0, 4'hF, "R3");
        run_op({16'h0005, 16'h0005, 16'h0009, 16'h0005, 16'h0007, 16'h0008, 16'h0009, 16'h000A},
               rnd_dest(), 1'b1, 1'b0, 4'hF, "R3");
        @(negedge clk);
        check(out_valid === 1'b0, "R9", "valid drops", VLEN'(out_valid), '0);
    endtask

    task automatic t_lane7();  // R2: minimum only in the top lane
        run_op({16'h0001, {7{16'h0002}}}, rnd_dest(), 1'b0, 1'b0, 4'hF, "R2");
        run_op({16'h7FFF, {7{16'h8000}}}, rnd_dest(), 1'b1, 1'b0, 4'hF, "R2");
    endtask

    task automatic t_extremes(); // R1: zero minimum and all-ones source
        run_op({16'hFFFF, 16'h8000, 16'h0000, {5{16'hFFFF}}}, rnd_dest(), 1'b0, 1'b0, 4'hF, "R1");
        run_op({8{16'hFFFF}}, rnd_dest(), 1'b1, 1'b0, 4'hF, "R1");
        run_op({8{16'hFFFF}}, rnd_dest(), 1'b0, 1'b0, 4'hF, "R4");
    endtask

    task automatic t_random(); // R1 R2 R4 R5 R6 over mixed data
        for (int n = 0; n < 40; n++) begin
            logic [127:0] s;
            for (int i = 0; i < 4; i++) s[i*32 +: 32] = $urandom;
            run_op(s, rnd_dest(), n[0], 1'b0, 4'hF, n[0] ? "R6" : "R5");
        end
    endtask

    task automatic t_legacy_fields(); // R5: fields have no effect in legacy mode
        for (int l = 0; l < 2; l++)
            for (int x = 0; x < 16; x++)
                run_op({16'h4000, 16'h3000, 16'h2000, 16'h1000, 16'h0900,
                        16'h0800, 16'h0700, 16'h0600}, rnd_dest(), 1'b0, l[0], 4'(x), "R5");
    endtask

    task automatic t_illegal(); // R7 R8: every illegal extended combination
        for (int l = 0; l < 2; l++)
            for (int x = 0; x < 16; x++)
                if (!(l == 0 && x == 15))
                    run_op({16'h0003, 16'h0002, 16'h0001, 16'h0004, {4{16'h0010}}},
                           rnd_dest(), 1'b1, l[0], 4'(x), "R8");
    endtask

    initial begin
        void'($urandom(7));
        t_reset();
        t_ties();
        t_lane7();
        t_extremes();
        t_random();
        t_legacy_fields();
        t_illegal();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule